// File: doc/BRIEF.md
# RTC Periodic Tick Generator

This block produces a periodic tick interrupt for a real-time-clock subsystem. It runs from the system clock. A single-cycle enable strobe arrives at a nominal 32768 Hz. A power-of-two prescaler thins that strobe down to the tick rate. A down-counter counts divided ticks, and each time it runs out it raises a pending flag and the tick interrupt line. It then reloads the programmed period and keeps running. The same control word also starts and stops a separate seconds divider, which emits a one-cycle pulse once every `SEC_DIV` strobes for a calendar block outside this one.

Software reaches the block through a small word-addressed register port. Writes land on the clock edge where `reg_we` is high. Reads are combinational from `reg_addr`. The port has no handshake, so a write always completes in one cycle.

The register map uses word offsets. Offset 0x0 is the control word. Offset 0x1 holds the tick period. Offset 0x2 is the pending flag. Offset 0x3 is the live counter. The control word has these fields:
- bit 0 is the master run enable;
- bits 7:4 select the prescaler exponent N;
- bit 8 is the tick enable.

The control word stores only bits 8:4 and 0, and other bits read back as zero.

Starting and stopping depend on edges, not levels. The block compares each newly written control word with the stored one. It acts only when the write changes an enable bit.

Top module: `rtc_tick_gen`

## Requirements
- R1: After reset every register (offsets 0x0 to 0x3) reads zero, `tick_irq` is low, `sec_pulse` is low, and both counters are stopped.
- R2: A write of a value of 2 or less to the period register (offset 0x1) is ignored and the previous value is kept. A value of 3 or more is stored.
- R3: A control write (offset 0x0) with bit 0 set starts the tick counter only if three things hold:
  - the write takes bit 8 from 0 to 1;
  - bit 0 is set in that write;
  - the stored period is nonzero.

  Starting loads the period into the live counter. A write that leaves bit 8 at 1, or one made while the period is zero, does not start it.
- R4: While running, the counter decrements once every 2^N strobes, with N taken from control bits 7:4. The first expiry comes T*2^N strobes after the start write, where T is the period. The exponent is latched only from control writes with bit 0 set.
- R5: On expiry the block sets pending bit 0 (offset 0x2) and raises `tick_irq`. It reloads the stored period on the same edge and keeps counting, so the next expiry follows one full period later.
- R6: Writing 1 to pending bit 0 clears it and drops `tick_irq`. Writing 0 has no effect. If an expiry happens in the same cycle as the clear, the expiry wins.
- R7: The tick counter stops, and its value freezes, in two cases:
  - a control write with bit 0 set takes bit 8 from 1 to 0;
  - a control write takes bit 0 from 1 to 0.
- R8: A read at offset 0x3 returns the live down-counter, which runs from T down to 1 between expiries.
- R9: No counter advances in a cycle where `strobe_32k` is low.
- R10: A control write that takes bit 0 from 0 to 1 restarts the seconds divider from zero. `sec_pulse` is then high for exactly one cycle after every `SEC_DIV` strobes. A write that takes bit 0 from 1 to 0 stops the divider and no further pulse appears.
- R11: Offsets other than 0x0 to 0x3 read as zero and ignore writes. Writes to offset 0x3 are also ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_32k | input | 1 | One-cycle enable at the 32768 Hz base rate |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register word offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from `reg_addr` |
| tick_irq | output | 1 | Tick interrupt, high while pending bit 0 is set |
| sec_pulse | output | 1 | One-cycle pulse at each seconds-divider wrap |

## Verification
The assertions assume the following about the inputs:
- at most one register write happens per cycle, on the edge where `reg_we` is high;
- `reg_addr` is stable for the whole cycle in which a read is sampled;
- `SEC_DIV` is at least 2, so a seconds pulse can never last two cycles.

The stimulus changes every input at the falling clock edge and issues single-cycle writes only. It keeps the strobe either held high or held low for long stretches, so every expiry cycle is known exactly. The bench sets `SEC_DIV` to 16 so that the seconds wrap can be reached in a few cycles.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
  // word offsets of the register port
  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_COUNT = 1;
  localparam int unsigned OFS_PEND  = 2;
  localparam int unsigned OFS_CUR   = 3;

  // control word fields
  localparam int unsigned CTL_RUN_BIT  = 0;
  localparam int unsigned CTL_SEL_LSB  = 4;
  localparam int unsigned CTL_SEL_W    = 4;
  localparam int unsigned CTL_TICK_BIT = 8;
  localparam logic [31:0] CTL_KEEP_MASK = 32'h0000_01F1;

  // smallest period value that is accepted
  localparam int unsigned MIN_PERIOD = 3;

  typedef struct packed {
    logic tick_start;
    logic tick_stop;
    logic sec_start;
    logic sec_stop;
  } ctl_events_t;
endpackage

// File: rtl/rtc_tick_divider.sv
module rtc_tick_divider #(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             div_tick
);
  localparam int unsigned PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  // low sel bits all ones marks the last strobe of each 2^sel group
  assign mask     = (PRE_W'(1) << sel) - PRE_W'(1);
  assign div_tick = strobe && run && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart) begin
      pre_q <= '0;
    end else if (strobe && run) begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             div_tick,
  input  logic [CNT_W-1:0] period,
  output logic             running,
  output logic             expire,
  output logic [CNT_W-1:0] count
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  assign expire  = run_q && div_tick && (cnt_q <= CNT_W'(1)) && !start && !stop;
  assign running = run_q;
  assign count   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= period;
    end else if (stop) begin
      run_q <= 1'b0;
    end else if (expire) begin
      cnt_q <= period;
    end else if (run_q && div_tick) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/rtc_sec_divider.sv
module rtc_sec_divider #(
  parameter int unsigned SEC_DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic start,
  input  logic stop,
  output logic pulse
);
  localparam int unsigned SW = (SEC_DIV > 1) ? $clog2(SEC_DIV) : 1;
  localparam logic [SW-1:0] LAST = SW'(SEC_DIV - 1);

  logic          run_q;
  logic          pulse_q;
  logic [SW-1:0] cnt_q;

  assign pulse = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (start) begin
      run_q   <= 1'b1;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (stop) begin
      run_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (run_q && strobe) begin
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          pulse_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + SW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen
  import rtc_tick_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned SEC_DIV = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_32k,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tick_irq,
  output logic              sec_pulse
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(CTL_KEEP_MASK);

  logic [DATA_W-1:0]    ctrl_q;
  logic [CNT_W-1:0]     period_q;
  logic [CTL_SEL_W-1:0] sel_q;
  logic                 pend_q;

  logic        wr_ctrl, wr_count, wr_pend;
  logic        new_run, old_run, new_tick, old_tick;
  ctl_events_t ev;

  logic             div_tick, tick_run, expire;
  logic [CNT_W-1:0] live_cnt;

  assign wr_ctrl  = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
  assign wr_count = reg_we && (reg_addr == ADDR_W'(OFS_COUNT));
  assign wr_pend  = reg_we && (reg_addr == ADDR_W'(OFS_PEND));

  assign new_run  = reg_wdata[CTL_RUN_BIT];
  assign old_run  = ctrl_q[CTL_RUN_BIT];
  assign new_tick = reg_wdata[CTL_TICK_BIT];
  assign old_tick = ctrl_q[CTL_TICK_BIT];

  // edge detection between the written word and the stored word
  always_comb begin
    ev            = '0;
    ev.tick_start = wr_ctrl && new_run && new_tick && !old_tick && (period_q != '0);
    ev.tick_stop  = wr_ctrl && ((new_run && !new_tick && old_tick) || (!new_run && old_run));
    ev.sec_start  = wr_ctrl && new_run && !old_run;
    ev.sec_stop   = wr_ctrl && !new_run && old_run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      sel_q    <= '0;
      period_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= reg_wdata & KEEP;
        if (new_run) begin
          sel_q <= reg_wdata[CTL_SEL_LSB +: CTL_SEL_W];
        end
      end
      if (wr_count && (reg_wdata[CNT_W-1:0] >= CNT_W'(MIN_PERIOD))) begin
        period_q <= reg_wdata[CNT_W-1:0];
      end
      if (expire) begin
        pend_q <= 1'b1;
      end else if (wr_pend && reg_wdata[0]) begin
        pend_q <= 1'b0;
      end
    end
  end

  rtc_tick_divider #(.SEL_W(CTL_SEL_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe_32k),
    .run      (tick_run),
    .restart  (ev.tick_start),
    .sel      (sel_q),
    .div_tick (div_tick)
  );

  rtc_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ev.tick_start),
    .stop     (ev.tick_stop),
    .div_tick (div_tick),
    .period   (period_q),
    .running  (tick_run),
    .expire   (expire),
    .count    (live_cnt)
  );

  rtc_sec_divider #(.SEC_DIV(SEC_DIV)) u_sec (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe_32k),
    .start  (ev.sec_start),
    .stop   (ev.sec_stop),
    .pulse  (sec_pulse)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(OFS_CTRL))       reg_rdata = ctrl_q;
    else if (reg_addr == ADDR_W'(OFS_COUNT)) reg_rdata = DATA_W'(period_q);
    else if (reg_addr == ADDR_W'(OFS_PEND))  reg_rdata = DATA_W'(pend_q);
    else if (reg_addr == ADDR_W'(OFS_CUR))   reg_rdata = DATA_W'(live_cnt);
  end

  assign tick_irq = pend_q;
endmodule

// File: rtl/rtc_tick_gen_checker.sv
module rtc_tick_gen_checker
  import rtc_tick_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strobe_32k,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              tick_irq,
  input logic              sec_pulse,
  input logic              tick_run,
  input logic              tick_start,
  input logic              expire,
  input logic [CNT_W-1:0]  live_cnt,
  input logic [CNT_W-1:0]  period_q
);
  AST_PERIOD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (period_q == '0) || (period_q >= CNT_W'(MIN_PERIOD))); // R2

  AST_IRQ_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_irq) |-> $past(expire)); // R5

  AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (live_cnt == $past(period_q))); // R5

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == ADDR_W'(OFS_PEND) && reg_wdata[0] && !expire) |=> !tick_irq); // R6

  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_run && !tick_start) |=> $stable(live_cnt)); // R7

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_32k && !tick_start) |=> $stable(live_cnt)); // R9

  AST_SEC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > ADDR_W'(OFS_CUR)) |-> (reg_rdata == '0)); // R11
endmodule

bind rtc_tick_gen rtc_tick_gen_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strobe_32k (strobe_32k),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .tick_irq   (tick_irq),
  .sec_pulse  (sec_pulse),
  .tick_run   (tick_run),
  .tick_start (ev.tick_start),
  .expire     (expire),
  .live_cnt   (live_cnt),
  .period_q   (period_q)
);

// File: tb/rtc_tick_gen_bench.sv
module rtc_tick_gen_bench;
  localparam int SECD = 16;
  localparam logic [3:0] A_CTRL = 4'h0, A_COUNT = 4'h1, A_PEND = 4'h2, A_CUR = 4'h3;
  // {N, T, expected cycles from start write to first expiry = T * 2^N}
  localparam int VEC [6][3] = '{
    '{0, 3, 3}, '{0, 10, 10}, '{1, 5, 10}, '{2, 4, 16}, '{3, 3, 24}, '{4, 7, 112}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b1;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, sec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_tick_gen #(.SEC_DIV(SECD)) u_rtc_tick_gen (
    .clk(clk), .rst_n(rst_n), .strobe_32k(strobe), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .tick_irq(irq), .sec_pulse(sec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // returns at the falling edge just after the write edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, r;
    int highs;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, r);  chk("R1 ctrl", r, 0);
    rd(A_COUNT, r); chk("R1 count", r, 0);
    rd(A_PEND, r);  chk("R1 pend", r, 0);
    rd(A_CUR, r);   chk("R1 cur", r, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sec", sec, 0);

    // R10 seconds divider start, R3 no start with zero period
    wr(A_CTRL, 32'h101);
    cyc(SECD - 1); chk("R10 before wrap", sec, 0);
    cyc(1);        chk("R10 wrap pulse", sec, 1);
    cyc(1);        chk("R10 pulse one cycle", sec, 0);
    rd(A_CUR, r);  chk("R3 zero period no start", r, 0);
    chk("R3 zero period irq", irq, 0);

    // R2 period validation
    wr(A_COUNT, 2); rd(A_COUNT, r); chk("R2 reject 2", r, 0);
    wr(A_COUNT, 1); rd(A_COUNT, r); chk("R2 reject 1", r, 0);
    wr(A_COUNT, 5); rd(A_COUNT, r); chk("R2 accept 5", r, 5);
    wr(A_COUNT, 2); rd(A_COUNT, r); chk("R2 keep previous", r, 5);

    // R3 no edge on bit 8: no start
    wr(A_CTRL, 32'h101);
    cyc(10);
    rd(A_CUR, r); chk("R3 level not edge", r, 0);
    chk("R3 level irq", irq, 0);

    // R11 unmapped offsets
    wr(4'hA, 32'hFFFF_FFFF);
    rd(4'hA, r);    chk("R11 unmapped read", r, 0);
    rd(A_COUNT, r); chk("R11 count untouched", r, 5);
    rd(A_CTRL, r);  chk("R11 ctrl untouched", r, 32'h101);
    wr(A_CUR, 32'h77);
    rd(A_CUR, r);   chk("R11 cur write ignored", r, 0);

    // vector table: R4 prescaler timing, R8 live count, R5 expiry and reload
    for (int i = 0; i < 6; i++) begin
      wr(A_CTRL, 0);
      wr(A_PEND, 1);
      wr(A_COUNT, VEC[i][1]);
      wr(A_CTRL, 32'h101 | (VEC[i][0] << 4));
      rd(A_CUR, r); chk("R3 load on start", r, VEC[i][1]);
      cyc(VEC[i][2] - 1);
      chk("R4 no early expiry", irq, 0);
      rd(A_CUR, r); chk("R8 live count last", r, 1);
      cyc(1);
      chk("R4 expiry cycle", irq, 1);
      rd(A_PEND, r); chk("R5 pending bit", r, 1);
      rd(A_CUR, r);  chk("R5 reload", r, VEC[i][1]);
    end

    // R6 write-one-to-clear
    wr(A_PEND, 0); chk("R6 zero no effect", irq, 1);
    wr(A_PEND, 1); chk("R6 clear", irq, 0);

    // R5 continuous operation, second expiry
    wr(A_CTRL, 0);
    wr(A_COUNT, 4);
    wr(A_CTRL, 32'h101);
    cyc(4); chk("R5 first expiry", irq, 1);
    cyc(1); rd(A_CUR, r); chk("R5 keeps counting", r, 3);
    wr(A_PEND, 1); chk("R6 cleared before next", irq, 0);
    cyc(1); chk("R5 second expiry", irq, 1);

    // R7 stop by bit 8 falling with bit 0 set
    wr(A_CTRL, 32'h001);
    wr(A_PEND, 1);
    rd(A_CUR, v);
    cyc(30);
    rd(A_CUR, r); chk("R7 frozen by tick disable", r, v);
    chk("R7 no irq after stop", irq, 0);

    // R7 and R10 stop by bit 0 falling
    wr(A_CTRL, 32'h101);
    wr(A_CTRL, 32'h100);
    rd(A_CUR, v);
    highs = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (sec) highs++;
    end
    chk("R10 no pulse after stop", highs, 0);
    rd(A_CUR, r); chk("R7 frozen by run disable", r, v);
    chk("R7 irq stays low", irq, 0);

    // R9 strobe gating
    strobe = 1'b0;
    wr(A_CTRL, 0);
    wr(A_CTRL, 32'h101);
    cyc(20);
    rd(A_CUR, r); chk("R9 no strobe no count", r, 4);
    chk("R9 no strobe no irq", irq, 0);
    strobe = 1'b1;
    cyc(3);
    rd(A_CUR, r); chk("R9 resumes", r, 1);
    chk("R9 no irq yet", irq, 0);
    cyc(1);
    chk("R9 expiry after resume", irq, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule